// File: doc/BRIEF.md
# March Test Self-Test Sequencer

This block is a built-in self-test engine for a RAM that stores one bit per word. After a start pulse it walks the RAM through one of six March algorithms. A March algorithm is a series of elements. Each element has an address direction and a short list of reads and writes, and every operation in that list is applied to one word before the address moves on. The engine issues exactly one RAM operation per clock. Each read is checked against the value it is expected to return. When the sequence is over, the engine reports pass or fail, together with the location of the first mismatch.

A constant table of elements, written as a function in the package, describes every algorithm. A single address counter and a single element/operation sequencer therefore serve all of them. The attached RAM returns read data one cycle after the request, and the expected bit travels through a one-stage pipeline so that it meets that data. The RAM size is given as the highest address (`top_addr`, which is n-1). It is sampled together with the algorithm code when a start is accepted.

The RAM side and the control side are plain level and pulse signals. There is no stream on this block, so there is no valid/ready handshake and no back-pressure. A request is issued on every cycle in which `ram_en` is high, and the RAM must accept it.

Top module: `march_bist`

## Requirements
- R1: After reset the block is idle. `ram_en`, `done` and `fail` are low, and `fail_addr` and `fail_elem` are zero.
- R2: Op encoding: `ram_we`=1 is a write of `ram_wdata`, and `ram_we`=0 is a read. While a test runs, `ram_en` is high on every cycle. All operations of an element are applied to one address, in list order, before the address moves.
- R3: Elements numbered from 0 use these directions (U = 0 up to n-1, D = n-1 down to 0). MATS, MATS+ and MATS++: U,U,D. March X and March Y: U,U,D,U. March C-: U,U,U,D,D,U.
- R4: `alg_sel` codes: 0 MATS {w0; r0,w1; r1}. 1 MATS+ {w0; r0,w1; r1,w0}. 2 MATS++ {w0; r0,w1; r1,w0,r0}. 3 March X {w0; r0,w1; r1,w0; r0}. 4 March C- {w0; r0,w1; r1,w0; r0,w1; r1,w0; r0}. 5 March Y {w0; r0,w1,r1; r1,w0,r0; r0}. Codes 6 and 7 run MATS.
- R5: One run issues exactly 4n (MATS), 5n (MATS+), 6n (MATS++, March X), 8n (March Y) or 10n (March C-) RAM operations.
- R6: `ram_rdata` is compared one cycle after each read request. Any mismatch sets `fail`. The address and the 0-based element index of the first mismatch are captured in `fail_addr` and `fail_elem` and are not overwritten by later mismatches.
- R7: A mismatch does not stop the run. The full operation sequence is still issued.
- R8: `done` is high for exactly one cycle, two cycles after the cycle of the last RAM operation. At that point `fail` already includes the result of the last read.
- R9: `fail`, `fail_addr` and `fail_elem` hold after `done` until the next accepted start, which clears them.
- R10: `alg_sel` and `top_addr` are sampled only when a start is accepted while idle. A start pulse or a change of `alg_sel`/`top_addr` during a run has no effect on the run.
- R11: The smallest RAM (`top_addr`=0, n=1) and the largest (`top_addr`=2^AW-1) run the full sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse, honoured while idle |
| alg_sel | input | 3 | Algorithm code (R4) |
| top_addr | input | AW | Highest RAM address, n-1 |
| ram_en | output | 1 | RAM operation this cycle |
| ram_we | output | 1 | 1 = write, 0 = read |
| ram_addr | output | AW | RAM word address |
| ram_wdata | output | 1 | Write data bit |
| ram_rdata | input | 1 | Read data, one cycle after the request |
| done | output | 1 | One-cycle end-of-test pulse |
| fail | output | 1 | A read mismatched since the last start |
| fail_addr | output | AW | Address of the first mismatch |
| fail_elem | output | 3 | Element index of the first mismatch |

## Verification
The hardest situations to reach from the ports are a mismatch that first appears on the very last read of a run, which must reach `fail` before `done`, and a first mismatch that is followed by later ones that must not overwrite the capture. The bench attaches a RAM model with an injectable stuck-at cell. Directed cases place the stuck cell at address 0 under a descending final element, and random cases pick the algorithm, size, cell and stuck value. A bench-side interpreter of the algorithm strings predicts the full operation trace and the first failing address and element for each case.

// File: rtl/march_bist_pkg.sv
package march_bist_pkg;

  localparam int ALG_W  = 3;
  localparam int ELEM_W = 3;
  localparam int OPI_W  = 2;

  // bit1 = write, bit0 = data / expected value
  typedef enum logic [1:0] {
    OP_R0 = 2'b00,
    OP_R1 = 2'b01,
    OP_W0 = 2'b10,
    OP_W1 = 2'b11
  } op_e;

  typedef enum logic [ALG_W-1:0] {
    ALG_MATS   = 3'd0,
    ALG_MATSP  = 3'd1,
    ALG_MATSPP = 3'd2,
    ALG_MX     = 3'd3,
    ALG_MCM    = 3'd4,
    ALG_MY     = 3'd5
  } alg_e;

  typedef struct packed {
    logic             down;
    logic [OPI_W-1:0] nops;
    op_e              op2;
    op_e              op1;
    op_e              op0;
  } elem_t;

  function automatic elem_t mk(logic d, logic [OPI_W-1:0] n, op_e a, op_e b, op_e c);
    elem_t r;
    r.down = d;
    r.nops = n;
    r.op0  = a;
    r.op1  = b;
    r.op2  = c;
    return r;
  endfunction

  function automatic alg_e norm_alg(logic [ALG_W-1:0] s);
    return (s > 3'd5) ? ALG_MATS : alg_e'(s);
  endfunction

  function automatic logic [ELEM_W-1:0] last_elem(alg_e a);
    case (a)
      ALG_MX, ALG_MY: return 3'd3;
      ALG_MCM:        return 3'd5;
      default:        return 3'd2;
    endcase
  endfunction

  // Element table: direction, op count and op list of element e of algorithm a
  function automatic elem_t elem_info(alg_e a, logic [ELEM_W-1:0] e);
    elem_t r;
    r = mk(1'b0, 2'd1, OP_R0, OP_R0, OP_R0);
    if (e == 3'd0) begin
      r = mk(1'b0, 2'd1, OP_W0, OP_R0, OP_R0);
    end else if (e == 3'd1) begin
      if (a == ALG_MY) r = mk(1'b0, 2'd3, OP_R0, OP_W1, OP_R1);
      else             r = mk(1'b0, 2'd2, OP_R0, OP_W1, OP_R0);
    end else begin
      case (a)
        ALG_MATS:   if (e == 3'd2) r = mk(1'b1, 2'd1, OP_R1, OP_R0, OP_R0);
        ALG_MATSP:  if (e == 3'd2) r = mk(1'b1, 2'd2, OP_R1, OP_W0, OP_R0);
        ALG_MATSPP: if (e == 3'd2) r = mk(1'b1, 2'd3, OP_R1, OP_W0, OP_R0);
        ALG_MX: begin
          if (e == 3'd2)      r = mk(1'b1, 2'd2, OP_R1, OP_W0, OP_R0);
          else if (e == 3'd3) r = mk(1'b0, 2'd1, OP_R0, OP_R0, OP_R0);
        end
        ALG_MY: begin
          if (e == 3'd2)      r = mk(1'b1, 2'd3, OP_R1, OP_W0, OP_R0);
          else if (e == 3'd3) r = mk(1'b0, 2'd1, OP_R0, OP_R0, OP_R0);
        end
        ALG_MCM: begin
          case (e)
            3'd2:    r = mk(1'b0, 2'd2, OP_R1, OP_W0, OP_R0);
            3'd3:    r = mk(1'b1, 2'd2, OP_R0, OP_W1, OP_R0);
            3'd4:    r = mk(1'b1, 2'd2, OP_R1, OP_W0, OP_R0);
            default: r = mk(1'b0, 2'd1, OP_R0, OP_R0, OP_R0);
          endcase
        end
        default: r = mk(1'b0, 2'd1, OP_R0, OP_R0, OP_R0);
      endcase
    end
    return r;
  endfunction

  function automatic logic elem_down(alg_e a, logic [ELEM_W-1:0] e);
    elem_t t;
    t = elem_info(a, e);
    return t.down;
  endfunction

endpackage

// File: rtl/march_addr.sv
module march_addr
  import march_bist_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_acc,
  input  logic [AW-1:0] top_addr,
  input  logic          addr_load,
  input  logic          addr_step,
  input  logic          load_down,
  input  logic          busy,
  output logic [AW-1:0] addr,
  output logic          at_end
);

  logic [AW-1:0] top_q;
  logic [AW-1:0] addr_q;
  logic          dir_q;
  logic [AW-1:0] top_now;

  assign top_now = start_acc ? top_addr : top_q;
  assign at_end  = dir_q ? (addr_q == '0) : (addr_q == top_q);
  assign addr    = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q  <= '0;
      addr_q <= '0;
      dir_q  <= 1'b0;
    end else begin
      if (start_acc) top_q <= top_addr;
      if (addr_load) begin
        dir_q  <= load_down;
        addr_q <= load_down ? top_now : '0;
      end else if (addr_step) begin
        addr_q <= dir_q ? addr_q - 1'b1 : addr_q + 1'b1;
      end
    end
  end

  // R3: the address never leaves 0..n-1 during a run
  a_r3_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> addr_q <= top_q);

  // R10: the sampled size stays fixed through a run
  a_r10_top_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(top_q));

endmodule

// File: rtl/march_seq.sv
module march_seq
  import march_bist_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ALG_W-1:0]  alg_sel,
  input  logic              at_end,
  output logic              start_acc,
  output logic              issue,
  output op_e               cur_op,
  output logic [ELEM_W-1:0] elem_idx,
  output logic              addr_load,
  output logic              addr_step,
  output logic              load_down,
  output logic              done
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN} st_e;

  st_e               st_q;
  alg_e              alg_q;
  logic [ELEM_W-1:0] elem_q;
  logic [OPI_W-1:0]  opi_q;
  logic              done_q;

  elem_t cur;
  logic  last_op;
  logic  last_el;

  assign cur       = elem_info(alg_q, elem_q);
  assign last_op   = (opi_q == cur.nops - 2'd1);
  assign last_el   = (elem_q == last_elem(alg_q));
  assign start_acc = (st_q == S_IDLE) && start;
  assign issue     = (st_q == S_RUN);
  assign addr_step = issue && last_op && !at_end;
  assign addr_load = start_acc || (issue && last_op && at_end && !last_el);
  assign load_down = start_acc ? elem_down(norm_alg(alg_sel), 3'd0)
                               : elem_down(alg_q, elem_q + 3'd1);
  assign elem_idx  = elem_q;
  assign done      = done_q;

  always_comb begin
    case (opi_q)
      2'd0:    cur_op = cur.op0;
      2'd1:    cur_op = cur.op1;
      default: cur_op = cur.op2;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      alg_q  <= ALG_MATS;
      elem_q <= '0;
      opi_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (start) begin
            alg_q  <= norm_alg(alg_sel);
            elem_q <= '0;
            opi_q  <= '0;
            st_q   <= S_RUN;
          end
        end
        S_RUN: begin
          if (last_op) begin
            opi_q <= '0;
            if (at_end) begin
              if (last_el) st_q <= S_DRAIN;
              else         elem_q <= elem_q + 3'd1;
            end
          end else begin
            opi_q <= opi_q + 2'd1;
          end
        end
        default: begin
          st_q   <= S_IDLE;
          done_q <= 1'b1;
        end
      endcase
    end
  end

  // R8: done is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R2: the op index stays inside the current element's list
  a_r2_op_in_list: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> opi_q < cur.nops);

  // R10: the sampled algorithm stays fixed through a run
  a_r10_alg_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RUN) && $past(st_q == S_RUN) |-> $stable(alg_q));

endmodule

// File: rtl/march_resp.sv
module march_resp
  import march_bist_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_acc,
  input  logic              issue,
  input  op_e               cur_op,
  input  logic [AW-1:0]     addr,
  input  logic [ELEM_W-1:0] elem_idx,
  input  logic              ram_rdata,
  output logic              fail,
  output logic [AW-1:0]     fail_addr,
  output logic [ELEM_W-1:0] fail_elem
);

  logic              pend_q;
  logic              exp_q;
  logic [AW-1:0]     paddr_q;
  logic [ELEM_W-1:0] pelem_q;
  logic              fail_q;
  logic [AW-1:0]     faddr_q;
  logic [ELEM_W-1:0] felem_q;
  logic              mismatch;

  assign mismatch  = pend_q && (ram_rdata != exp_q);
  assign fail      = fail_q;
  assign fail_addr = faddr_q;
  assign fail_elem = felem_q;

  // expected bit and tag ride one stage to meet the RAM read latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      exp_q   <= 1'b0;
      paddr_q <= '0;
      pelem_q <= '0;
    end else begin
      pend_q  <= issue && !cur_op[1];
      exp_q   <= cur_op[0];
      paddr_q <= addr;
      pelem_q <= elem_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q  <= 1'b0;
      faddr_q <= '0;
      felem_q <= '0;
    end else if (start_acc) begin
      fail_q  <= 1'b0;
      faddr_q <= '0;
      felem_q <= '0;
    end else if (mismatch && !fail_q) begin
      fail_q  <= 1'b1;
      faddr_q <= paddr_q;
      felem_q <= pelem_q;
    end
  end

  // R6: any mismatch raises fail on the next cycle
  a_r6_mismatch_flags: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch && !start_acc |=> fail_q);

  // R6: the first capture is never overwritten
  a_r6_capture_kept: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q && !start_acc |=> $stable(faddr_q) && $stable(felem_q));

  // R9: fail stays until a start is accepted
  a_r9_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q && !start_acc |=> fail_q);

endmodule

// File: rtl/march_bist.sv
module march_bist
  import march_bist_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ALG_W-1:0]  alg_sel,
  input  logic [AW-1:0]     top_addr,
  output logic              ram_en,
  output logic              ram_we,
  output logic [AW-1:0]     ram_addr,
  output logic              ram_wdata,
  input  logic              ram_rdata,
  output logic              done,
  output logic              fail,
  output logic [AW-1:0]     fail_addr,
  output logic [ELEM_W-1:0] fail_elem
);

  logic              start_acc;
  logic              issue;
  op_e               cur_op;
  logic [ELEM_W-1:0] elem_idx;
  logic              addr_load;
  logic              addr_step;
  logic              load_down;
  logic [AW-1:0]     addr;
  logic              at_end;

  march_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .alg_sel   (alg_sel),
    .at_end    (at_end),
    .start_acc (start_acc),
    .issue     (issue),
    .cur_op    (cur_op),
    .elem_idx  (elem_idx),
    .addr_load (addr_load),
    .addr_step (addr_step),
    .load_down (load_down),
    .done      (done)
  );

  march_addr #(.AW(AW)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_acc (start_acc),
    .top_addr  (top_addr),
    .addr_load (addr_load),
    .addr_step (addr_step),
    .load_down (load_down),
    .busy      (issue),
    .addr      (addr),
    .at_end    (at_end)
  );

  march_resp #(.AW(AW)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_acc (start_acc),
    .issue     (issue),
    .cur_op    (cur_op),
    .addr      (addr),
    .elem_idx  (elem_idx),
    .ram_rdata (ram_rdata),
    .fail      (fail),
    .fail_addr (fail_addr),
    .fail_elem (fail_elem)
  );

  assign ram_en    = issue;
  assign ram_we    = issue && cur_op[1];
  assign ram_wdata = cur_op[0];
  assign ram_addr  = addr;

  // R2: no RAM operation while done is reported
  a_r2_quiet_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ram_en);

endmodule

// File: tb/tb_march_bist.sv
`timescale 1ns/1ps
module tb_march_bist;

  localparam int AW = 6;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [2:0]    alg_sel = '0;
  logic [AW-1:0] top_addr = '0;
  logic          ram_en, ram_we, ram_wdata;
  logic [AW-1:0] ram_addr;
  logic          ram_rdata = 1'b0;
  logic          done, fail;
  logic [AW-1:0] fail_addr;
  logic [2:0]    fail_elem;

  always #2.5 clk = ~clk;

  march_bist #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .alg_sel(alg_sel),
    .top_addr(top_addr), .ram_en(ram_en), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .done(done), .fail(fail), .fail_addr(fail_addr), .fail_elem(fail_elem)
  );

  // RAM model with an optional stuck-at cell, one-cycle read latency
  logic          mem [NW];
  bit            sa_en = 1'b0;
  int            sa_addr = 0;
  bit            sa_val = 1'b0;

  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we && !(sa_en && int'(ram_addr) == sa_addr)) mem[ram_addr] <= ram_wdata;
      ram_rdata <= (sa_en && int'(ram_addr) == sa_addr) ? sa_val : mem[ram_addr];
    end
  end

  int total = 0;
  int bad   = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Algorithm text: '+' up element, '-' down element, then op pairs
  function automatic string alg_str(int a);
    case (a)
      1: return "+w0+r0w1-r1w0";
      2: return "+w0+r0w1-r1w0r0";
      3: return "+w0+r0w1-r1w0+r0";
      4: return "+w0+r0w1+r1w0-r0w1-r1w0+r0";
      5: return "+w0+r0w1r1-r1w0r0+r0";
      default: return "+w0+r0w1-r1";
    endcase
  endfunction

  function automatic int ops_per_cell(int a);
    case (a)
      1: return 5;
      2, 3: return 6;
      4: return 10;
      5: return 8;
      default: return 4;
    endcase
  endfunction

  int  exp_n;
  int  exp_addr [2048];
  bit  exp_we   [2048];
  bit  exp_wd   [2048];
  bit  exp_fail;
  int  exp_faddr, exp_felem;
  bit  init_pat [NW];

  task automatic build_model(int a, int top);
    string s;
    int    ne;
    bit    dn [8];
    int    nop [8];
    bit    ow [8][4];
    bit    ov [8][4];
    bit    bm [NW];
    s  = alg_str(a);
    ne = 0;
    for (int i = 0; i < s.len(); i++) begin
      byte c;
      c = s.getc(i);
      if (c == "+" || c == "-") begin
        dn[ne] = (c == "-");
        nop[ne] = 0;
        ne++;
      end else begin
        ow[ne-1][nop[ne-1]] = (c == "w");
        ov[ne-1][nop[ne-1]] = (s.getc(i+1) == "1");
        nop[ne-1]++;
        i++;
      end
    end
    for (int i = 0; i < NW; i++) bm[i] = init_pat[i];
    exp_n = 0; exp_fail = 0; exp_faddr = 0; exp_felem = 0;
    for (int e = 0; e < ne; e++) begin
      for (int j = 0; j <= top; j++) begin
        int ad;
        ad = dn[e] ? top - j : j;
        for (int k = 0; k < nop[e]; k++) begin
          exp_addr[exp_n] = ad;
          exp_we[exp_n]   = ow[e][k];
          exp_wd[exp_n]   = ov[e][k];
          exp_n++;
          if (ow[e][k]) begin
            if (!(sa_en && ad == sa_addr)) bm[ad] = ov[e][k];
          end else begin
            bit rv;
            rv = (sa_en && ad == sa_addr) ? sa_val : bm[ad];
            if (rv != ov[e][k] && !exp_fail) begin
              exp_fail = 1; exp_faddr = ad; exp_felem = e;
            end
          end
        end
      end
    end
  endtask

  task automatic run_case(string nm, int a, int top, bit fe, int fa, bit fv, bit mid);
    int  n, mism, cyc, last_cyc;
    bit  injected;
    sa_en = fe; sa_addr = fa; sa_val = fv;
    for (int i = 0; i < NW; i++) begin
      init_pat[i] = 1'($urandom);
      mem[i] = init_pat[i];
    end
    build_model(a, top);
    @(negedge clk);
    start = 1'b1; alg_sel = 3'(a); top_addr = AW'(top);
    @(negedge clk);
    start = 1'b0;
    chk(fail == 1'b0, "R9", {nm, " fail cleared by start"}, fail, 0);
    n = 0; mism = 0; cyc = 0; last_cyc = 0; injected = 0;
    // first op cycle is this one
    forever begin
      if (done) break;
      if (ram_en) begin
        if (n < exp_n) begin
          if (int'(ram_addr) != exp_addr[n] || ram_we != exp_we[n] ||
              (ram_we && ram_wdata != exp_wd[n])) mism++;
        end else mism++;
        n++;
        last_cyc = cyc;
      end
      @(negedge clk);
      cyc++;
      start = 1'b0;
      if (mid && !injected && n == 3) begin
        start = 1'b1; alg_sel = 3'((a + 1) % 6); top_addr = ~AW'(top);
        injected = 1;
      end
      if (cyc > 20000) begin
        chk(0, "R8", {nm, " watchdog"}, cyc, 0);
        break;
      end
    end
    start = 1'b0;
    chk(n == ops_per_cell(a) * (top + 1), "R5", {nm, " op count"}, n, ops_per_cell(a) * (top + 1));
    chk(mism == 0, "R3", {nm, " op/address trace (R2 R4)"}, mism, 0);
    chk(cyc - last_cyc == 2, "R8", {nm, " done two cycles after last op"}, cyc - last_cyc, 2);
    chk(fail == exp_fail, "R6", {nm, " fail flag (R7)"}, fail, exp_fail);
    if (exp_fail) begin
      chk(int'(fail_addr) == exp_faddr, "R6", {nm, " first fail address"}, fail_addr, exp_faddr);
      chk(int'(fail_elem) == exp_felem, "R6", {nm, " first fail element"}, fail_elem, exp_felem);
    end
    @(negedge clk);
    chk(done == 1'b0, "R8", {nm, " done single cycle"}, done, 0);
    repeat (3) @(negedge clk);
    chk(fail == exp_fail, "R9", {nm, " fail held after done"}, fail, exp_fail);
  endtask

  initial begin
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    chk(!ram_en && !done && !fail && fail_addr == '0 && fail_elem == '0,
        "R1", "reset state", {ram_en, done, fail}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ram_en == 1'b0, "R1", "idle after reset", ram_en, 0);

    for (int a = 0; a < 6; a++) run_case("clean", a, 7, 0, 0, 0, 0);
    run_case("code6", 6, 5, 0, 0, 0, 0);   // R4 unused codes run MATS
    run_case("code7", 7, 4, 0, 0, 0, 0);
    run_case("n1", 4, 0, 0, 0, 0, 0);      // R11 smallest
    run_case("nmax", 5, NW - 1, 0, 0, 0, 0); // R11 largest
    run_case("n1fault", 2, 0, 1, 0, 1, 0);
    run_case("lastread", 0, 7, 1, 0, 0, 0); // mismatch on final read
    run_case("sa1", 4, 15, 1, 9, 1, 0);
    run_case("midstart", 3, 9, 0, 0, 0, 1);  // R10
    run_case("midfault", 5, 12, 1, 12, 0, 1);
    run_case("clean_after", 1, 6, 0, 0, 0, 0);
    for (int r = 0; r < 14; r++) begin
      int a, t;
      a = int'($urandom_range(0, 7));
      t = int'($urandom_range(0, NW - 1));
      run_case("rand", a, t, 1'($urandom), int'($urandom_range(0, t)), 1'($urandom), 1'($urandom));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule